// File: doc/BRIEF.md
# Four-Input Scan Sequencer

This block steps a four-input sampling front end through a group of channels. Software writes one configuration word. Its low field is a mode code that names the group to scan: one channel alone, the even-aligned pair 0/1 or 2/3, or all four channels counting upward. The same word carries the enable and AC-coupling controls for each channel pair. When a pair is not enabled, the analog side grounds it.

Every pulse on the sample strobe moves the channel output to the next member of the group. After the last member it wraps back to the first. A start-of-scan flag marks every sample taken on the first channel of the group, so downstream logic can frame scans without counting. Mode code 0 parks the sequencer. The codes in the upper half of the mode field are reserved. Writing one of them leaves the running configuration untouched and raises a sticky error flag.

Top module: `scan_sequencer`

## Requirements
- R1: After a synchronous reset, `chan_idx` is 0, `first_of_scan` is 0, `pair_en` and `pair_ac` are 0, `cfg_err` is 0, and the mode is idle (code 0).
- R2: Mode codes 4 to 7 scan the single channel (code − 4). Every strobe selects that channel with `first_of_scan` high.
- R3: Mode code 2 alternates 0,1,0,1… and mode code 3 alternates 2,3,2,3… `first_of_scan` is high exactly when the lower channel of the pair is selected.
- R4: Mode code 1 counts 0,1,2,3 and wraps to 0. `first_of_scan` is high exactly on channel 0.
- R5: With mode code 0, strobes leave `chan_idx` unchanged. `first_of_scan` is low from the cycle after the code-0 write onward.
- R6: After any legal write, the next strobe selects the first channel of the new group with `first_of_scan` high, even in the middle of a scan. A strobe in the same cycle as the write already uses the new group. Without a strobe, `chan_idx` does not change.
- R7: The config word is laid out as follows: bits [3:0] hold the mode field, bit 4 enables pair 0/1, bit 5 enables pair 2/3, bit 6 AC-couples pair 0/1 and bit 7 AC-couples pair 2/3. A mode field of 8 to 15 is illegal. Such a write sets `cfg_err` and changes neither the mode, the channel sequence nor the pair controls.
- R8: One cycle after a legal write, `pair_en` = {bit 5, bit 4} and `pair_ac` = {bit 7, bit 6} of the written word. Index 0 of each output is pair 0/1.
- R9: Once set, `cfg_err` stays high through later legal writes. Only reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Config word write strobe |
| cfg_wdata | input | 8 | Config word: mode, pair enables, pair AC coupling |
| smp_strobe | input | 1 | Sample strobe, advances the sequence |
| chan_idx | output | 2 | Selected input channel |
| first_of_scan | output | 1 | Selected channel is the first of its group |
| pair_en | output | 2 | Pair enables (0: channels 0/1, 1: channels 2/3) |
| pair_ac | output | 2 | Pair AC-coupling controls |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The assertions assume that `cfg_we` and `smp_strobe` are clean, synchronous one-cycle pulses. They also assume that reset is held for at least two cycles, so that `$stable` and `$past` never compare against a half-reset cycle. The stimulus follows these assumptions. It drives every input on the falling clock edge, and it raises each write or strobe for exactly one cycle, using one write task and one strobe task. Reset is held for three cycles every time it is applied. The only overlap of a write and a strobe is the deliberate one that exercises R6.

// File: rtl/scan_seq_pkg.sv
// Package: shared widths, config field positions and the group decoder
// for the four-input scan sequencer.
// Assumes: exactly four channels; mode field of CODE_W+1 bits whose upper
// half of code space is reserved.
package scan_seq_pkg;
    localparam int NUM_CH   = 4;
    localparam int CH_W     = $clog2(NUM_CH);
    localparam int MODE_W   = 4;
    localparam int CODE_W   = MODE_W - 1;
    localparam int CFG_W    = MODE_W + 4;
    localparam int EN_LSB   = MODE_W;
    localparam int AC_LSB   = MODE_W + 2;

    typedef logic [CH_W-1:0]   chan_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  active;
        chan_t lo;
        chan_t hi;
    } group_t;

    // Map a legal mode code onto the bounds of its channel group.
    function automatic group_t decode_group(input code_t code);
        group_t g;
        g.active = 1'b1;
        g.lo     = '0;
        g.hi     = '0;
        if (code[CODE_W-1]) begin
            g.lo = code[CH_W-1:0];
            g.hi = code[CH_W-1:0];
        end else begin
            case (code[CH_W-1:0])
                2'd1:    begin g.lo = 2'd0; g.hi = 2'd3; end
                2'd2:    begin g.lo = 2'd0; g.hi = 2'd1; end
                2'd3:    begin g.lo = 2'd2; g.hi = 2'd3; end
                default: g.active = 1'b0;
            endcase
        end
        return g;
    endfunction
endpackage

// File: rtl/scan_cfg_reg.sv
// Config register: screens every write for a reserved mode code, holds
// the last legal mode and the pair controls, and keeps the sticky error.
// Assumes: cfg_we is a one-cycle synchronous pulse.
module scan_cfg_reg
    import scan_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             wr_ok,
    output code_t            wr_code,
    output code_t            mode_q,
    output logic [1:0]       pair_en,
    output logic [1:0]       pair_ac,
    output logic             cfg_err
);
    logic wr_bad;

    // Classify the incoming write as legal or reserved.
    always_comb begin
        wr_code = cfg_wdata[CODE_W-1:0];
        wr_ok   = cfg_we && !cfg_wdata[MODE_W-1];
        wr_bad  = cfg_we &&  cfg_wdata[MODE_W-1];
    end

    // Hold the last legal configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            pair_en <= '0;
            pair_ac <= '0;
        end else if (wr_ok) begin
            mode_q  <= wr_code;
            pair_en <= cfg_wdata[EN_LSB +: 2];
            pair_ac <= cfg_wdata[AC_LSB +: 2];
        end
    end

    // Sticky error: set by a reserved write, cleared by reset only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else if (wr_bad)
            cfg_err <= 1'b1;
    end
endmodule

// File: rtl/scan_chan_walker.sv
// Channel walker: on each strobe, selects the next channel of the active
// group, wrapping at its end, and flags the group's first channel.
// Assumes: a legal write forces a restart at the group's first channel;
// a strobe in the same cycle as the write already sees the new group.
module scan_chan_walker
    import scan_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  smp_strobe,
    input  logic  wr_ok,
    input  code_t wr_code,
    input  code_t mode_q,
    output chan_t chan_idx,
    output logic  first_of_scan
);
    logic   restart_pend;
    logic   restart;
    code_t  eff_code;
    group_t grp;

    // Pick the mode that applies to this cycle's strobe.
    always_comb begin
        eff_code = wr_ok ? wr_code : mode_q;
        restart  = wr_ok || restart_pend;
        grp      = decode_group(eff_code);
    end

    // Remember that a legal write is waiting for its first strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            restart_pend <= 1'b0;
        else if (smp_strobe)
            restart_pend <= 1'b0;
        else if (wr_ok)
            restart_pend <= 1'b1;
    end

    // Step the channel and the first-of-scan flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_idx      <= '0;
            first_of_scan <= 1'b0;
        end else if (smp_strobe && grp.active) begin
            if (restart || chan_idx == grp.hi) begin
                chan_idx      <= grp.lo;
                first_of_scan <= 1'b1;
            end else begin
                chan_idx      <= chan_t'(chan_idx + 1'b1);
                first_of_scan <= 1'b0;
            end
        end else if (wr_ok && !grp.active) begin
            first_of_scan <= 1'b0;
        end
    end
endmodule

// File: rtl/scan_sequencer.sv
// Top: four-input scan sequencer. Joins the config register and the
// channel walker.
// Assumes: synchronous active-low reset; one-cycle write and strobe pulses.
module scan_sequencer
    import scan_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             smp_strobe,
    output logic [CH_W-1:0]  chan_idx,
    output logic             first_of_scan,
    output logic [1:0]       pair_en,
    output logic [1:0]       pair_ac,
    output logic             cfg_err
);
    logic  wr_ok;
    code_t wr_code;
    code_t mode_q;

    scan_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .wr_ok     (wr_ok),
        .wr_code   (wr_code),
        .mode_q    (mode_q),
        .pair_en   (pair_en),
        .pair_ac   (pair_ac),
        .cfg_err   (cfg_err)
    );

    scan_chan_walker u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .smp_strobe    (smp_strobe),
        .wr_ok         (wr_ok),
        .wr_code       (wr_code),
        .mode_q        (mode_q),
        .chan_idx      (chan_idx),
        .first_of_scan (first_of_scan)
    );
endmodule

// File: rtl/scan_sequencer_chk.sv
// Checker: port-level properties of the scan sequencer, bound to the top.
// Assumes: reset is held for at least two cycles.
module scan_sequencer_chk
    import scan_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic             smp_strobe,
    input logic [CH_W-1:0]  chan_idx,
    input logic             first_of_scan,
    input logic [1:0]       pair_en,
    input logic [1:0]       pair_ac,
    input logic             cfg_err
);
    a_r5_idle_first_low: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[MODE_W-1:0] == '0) |=> !first_of_scan);

    a_r6_chan_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_strobe |=> $stable(chan_idx));

    a_r7_reserved_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[MODE_W-1]) |=> cfg_err);

    a_r7_reserved_keeps_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[MODE_W-1]) |=> ($stable(pair_en) && $stable(pair_ac)));

    a_r8_pairs_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wdata[MODE_W-1]) |=>
        (pair_en == $past(cfg_wdata[EN_LSB +: 2]) && pair_ac == $past(cfg_wdata[AC_LSB +: 2])));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

bind scan_sequencer scan_sequencer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .smp_strobe    (smp_strobe),
    .chan_idx      (chan_idx),
    .first_of_scan (first_of_scan),
    .pair_en       (pair_en),
    .pair_ac       (pair_ac),
    .cfg_err       (cfg_err)
);

// File: tb/tb_scan_sequencer.sv
`timescale 1ns/1ps
module tb_scan_sequencer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       smp_strobe = 1'b0;
    logic [1:0] chan_idx;
    logic       first_of_scan;
    logic [1:0] pair_en;
    logic [1:0] pair_ac;
    logic       cfg_err;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    scan_sequencer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .smp_strobe(smp_strobe), .chan_idx(chan_idx), .first_of_scan(first_of_scan),
        .pair_en(pair_en), .pair_ac(pair_ac), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_cfg(input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk); smp_strobe = 1'b1;
        @(negedge clk); smp_strobe = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 chan", chan_idx, 0);
        check("R1 first", first_of_scan, 0);
        check("R1 en", pair_en, 0);
        check("R1 ac", pair_ac, 0);
        check("R1 err", cfg_err, 0);
        strobe();
        check("R1 idle after reset", first_of_scan, 0);
    endtask

    task automatic t_single();
        for (int c = 4; c < 8; c++) begin
            write_cfg(8'(c));
            for (int k = 0; k < 3; k++) begin
                strobe();
                check("R2 chan", chan_idx, c - 4);
                check("R2 first", first_of_scan, 1);
            end
        end
    endtask

    task automatic t_pairs();
        write_cfg(8'h02);
        for (int k = 0; k < 5; k++) begin
            strobe();
            check("R3 pair01 chan", chan_idx, k % 2);
            check("R3 pair01 first", first_of_scan, (k % 2) == 0);
        end
        write_cfg(8'h03);
        for (int k = 0; k < 5; k++) begin
            strobe();
            check("R3 pair23 chan", chan_idx, 2 + k % 2);
            check("R3 pair23 first", first_of_scan, (k % 2) == 0);
        end
    endtask

    task automatic t_all();
        write_cfg(8'h01);
        for (int k = 0; k < 9; k++) begin
            strobe();
            check("R4 chan", chan_idx, k % 4);
            check("R4 first", first_of_scan, (k % 4) == 0);
        end
    endtask

    task automatic t_idle();
        write_cfg(8'h01);
        strobe(); strobe();
        write_cfg(8'h00);
        check("R5 first after idle write", first_of_scan, 0);
        for (int k = 0; k < 3; k++) begin
            strobe();
            check("R5 chan held", chan_idx, 1);
            check("R5 first low", first_of_scan, 0);
        end
    endtask

    task automatic t_restart();
        write_cfg(8'h01);
        strobe(); strobe(); strobe();
        write_cfg(8'h01);
        repeat (2) @(negedge clk);
        check("R6 no strobe no move", chan_idx, 2);
        strobe();
        check("R6 restart chan", chan_idx, 0);
        check("R6 restart first", first_of_scan, 1);
        strobe();
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 8'h03; smp_strobe = 1'b1;
        @(negedge clk); cfg_we = 1'b0; smp_strobe = 1'b0;
        check("R6 same-cycle chan", chan_idx, 2);
        check("R6 same-cycle first", first_of_scan, 1);
    endtask

    task automatic t_pair_ctl();
        write_cfg(8'b1001_0010);
        check("R8 en", pair_en, 2'b01);
        check("R8 ac", pair_ac, 2'b10);
        write_cfg(8'b0110_0101);
        check("R8 en swap", pair_en, 2'b10);
        check("R8 ac swap", pair_ac, 2'b01);
    endtask

    task automatic t_illegal();
        do_reset();
        write_cfg(8'h32);
        strobe(); strobe();
        write_cfg(8'h0C);
        check("R7 err set", cfg_err, 1);
        check("R7 en kept", pair_en, 2'b11);
        check("R7 ac kept", pair_ac, 2'b00);
        check("R7 chan kept", chan_idx, 1);
        strobe();
        check("R7 seq continues chan", chan_idx, 0);
        check("R7 seq continues first", first_of_scan, 1);
        strobe();
        check("R7 seq continues chan2", chan_idx, 1);
        write_cfg(8'h05);
        check("R9 err sticky", cfg_err, 1);
        strobe();
        check("R9 legal after err", chan_idx, 1);
        do_reset();
        check("R9 reset clears err", cfg_err, 0);
    endtask

    initial begin
        t_reset();
        t_single();
        t_pairs();
        t_all();
        t_idle();
        t_restart();
        t_pair_ctl();
        t_illegal();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule